// File: doc/BRIEF.md
# Multi-Mode Transient Capture Sequencer

This block steers waveform capture into a shared sample memory of 2^ADDR_W words (128K words by default). It does not convert or store samples. It decides which sample-rate tick reaches the track/hold front end, and which memory address each finished conversion is written to. It also stops the capture when the record is complete.

The host selects a capture style, a channel count and two post-trigger scan counts, then issues an arm command. Three capture styles are offered:

- **Triggered record.** The lower half of memory is a circular pre-trigger history. A trigger moves writing to the upper half. There, capture runs a near segment and then a far segment, each at its own rate, and then halts.
- **Continuous.** Capture runs at the pre-trigger rate over the whole memory without end. The half and full flags show which half is being filled.
- **Single scan.** Nothing is sampled until a trigger. Each trigger captures a burst of scans.

The channels of one scan always land at consecutive addresses, in ascending channel order. Because of this, the words available per channel shrink as the channel count grows. Three sticky status flags are available, and each can raise the interrupt output on its own.

Top module: `acq_sequencer`

## Requirements
- R1: The configuration is latched at arm. `chan_code_i` values 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 channels; values above 4 act as 16. A scan is that many conversions, written to consecutive ascending addresses.
- R2: Arm clears all flags and sets the write address to 0. `mode_i` is latched at arm: 0 is triggered, 1 is continuous, 2 is single scan, and 3 acts as triggered.
- R3: In triggered mode before the trigger, writes run circularly over addresses 0 to HALF-1, where HALF = 2^(ADDR_W-1). Address HALF-1 is followed by 0.
- R4: A trigger in triggered mode before the trigger does two things. It latches the current write address on `trig_addr_o`, and the next write goes to address HALF.
- R5: After the trigger, `near_cnt_i` scans are written at the near rate, then `far_cnt_i` scans at the far rate. A zero count skips its segment. At the end, capture halts, the full and end-of-event flags are set, and further conversions write nothing.
- R6: If a post-trigger write reaches address 2^ADDR_W-1, capture halts at once and the full and end-of-event flags are set.
- R7: In continuous mode, writes run over the whole memory and wrap to 0. The half flag is set by the write to HALF-1 and the full flag by the write to the top address. Capture never halts, and triggers are ignored.
- R8: In single scan mode, while waiting for a trigger, there are no sample ticks and no writes. A trigger gives a sample tick in the same cycle and starts the first scan. Further scans, up to a total of max(`near_cnt_i`, 1), follow at the near rate. Each scan sets the end-of-event flag. The block then waits again.
- R9: In single scan mode, the write to the top address sets the full and end-of-event flags and halts capture. Later triggers give no tick.
- R10: `rate_o` encodes the active rate: 0 none, 1 pre-trigger, 2 near, 3 far. `samp_tick_o` passes the matching tick input.
- R11: `flags_o` bit 0 is half, bit 1 is full and bit 2 is end-of-event. Flags stay set until a 1 is written to the matching bit of `clr_i`, or until an arm.
- R12: `irq_o` is high exactly when some flag is set whose bit in `irq_en_i` is 1.
- R13: `wr_en_o` is high only in a cycle with `conv_done_i` while capture is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm pulse: latch configuration and restart capture |
| mode_i | input | 2 | Capture style |
| chan_code_i | input | 3 | Channel count code |
| near_cnt_i | input | CNT_W | Near-segment scans (scans per trigger in single scan) |
| far_cnt_i | input | CNT_W | Far-segment scans |
| trig_i | input | 1 | Trigger pulse |
| tick_pre_i | input | 1 | Pre-trigger rate tick |
| tick_near_i | input | 1 | Near rate tick |
| tick_far_i | input | 1 | Far rate tick |
| conv_done_i | input | 1 | One conversion finished |
| clr_i | input | 3 | Write-one-to-clear for the flags |
| irq_en_i | input | 3 | Interrupt enables, one per flag |
| wr_addr_o | output | ADDR_W | Sample memory write address |
| wr_en_o | output | 1 | Sample memory write enable |
| rate_o | output | 2 | Active rate code |
| samp_tick_o | output | 1 | Gated sample tick to the front end |
| flags_o | output | 3 | Sticky status flags |
| irq_o | output | 1 | Interrupt request |
| trig_addr_o | output | ADDR_W | Write address latched at the trigger |

## Verification
Some properties are checked by assertions on every cycle:

- the channel slot never passes the last selected channel, and each write advances it by one;
- a halted capture issues no write and no tick;
- a waiting single-scan capture issues no write;
- continuous mode never leaves its running phase;
- a trigger moves the write address to HALF;
- set flags persist unless cleared.

The bench scenarios are what show the address sequences themselves: the circular history and its latched trigger address, the segment lengths and the rate changes between them, the multi-scan bursts, the early halt at the top address, and the interrupt masking.

// File: rtl/acq_seq_pkg.sv
`timescale 1ns/1ps
package acq_seq_pkg;

    typedef enum logic [1:0] {
        MODE_TRIG   = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } acq_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PRE, PH_NEAR, PH_FAR, PH_WAIT, PH_SCAN, PH_DONE
    } acq_phase_e;

    typedef enum logic [1:0] {
        RATE_NONE = 2'd0,
        RATE_PRE  = 2'd1,
        RATE_NEAR = 2'd2,
        RATE_FAR  = 2'd3
    } rate_e;

    // bit 2 end-of-event, bit 1 full, bit 0 half
    typedef struct packed {
        logic eoe;
        logic full;
        logic half;
    } flag_t;

    // log2 of the channel count; codes above 4 saturate to 16 channels
    function automatic logic [2:0] chan_log(input logic [2:0] code);
        return (code > 3'd4) ? 3'd4 : code;
    endfunction

    function automatic logic phase_writes(input acq_phase_e p);
        return (p == PH_PRE) || (p == PH_NEAR) || (p == PH_FAR) || (p == PH_SCAN);
    endfunction

endpackage

// File: rtl/acq_addr_gen.sv
`timescale 1ns/1ps
module acq_addr_gen #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] restart_val_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] lim_i,
    input  logic [2:0]        ch_log_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              scan_end_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        slot_q;
    logic [3:0]        last_slot;

    assign last_slot  = 4'((5'd1 << ch_log_i) - 5'd1);
    assign scan_end_o = wr_i && (slot_q == last_slot);
    assign addr_o     = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            slot_q <= '0;
        end else if (restart_i) begin
            addr_q <= restart_val_i;
            slot_q <= '0;
        end else if (wr_i) begin
            addr_q <= (addr_q == lim_i) ? base_i : addr_q + 1'b1;
            slot_q <= scan_end_o ? 4'd0 : slot_q + 4'd1;
        end
    end

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q <= last_slot);

    // R1
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !restart_i && !scan_end_o) |=> (slot_q == $past(slot_q) + 4'd1));

endmodule

// File: rtl/acq_flag_bank.sv
`timescale 1ns/1ps
module acq_flag_bank
    import acq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_all_i,
    input  flag_t      set_i,
    input  logic [2:0] clr_i,
    input  logic [2:0] en_i,
    output flag_t      flags_o,
    output logic       irq_o
);
    flag_t flags_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all_i) flags_q <= '0;
        else                  flags_q <= flag_t'((flags_q & ~clr_i) | set_i);
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_all_i |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == 3'b000));

endmodule

// File: rtl/acq_phase_fsm.sv
`timescale 1ns/1ps
module acq_phase_fsm
    import acq_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        chan_code_i,
    input  logic [CNT_W-1:0]  near_cnt_i,
    input  logic [CNT_W-1:0]  far_cnt_i,
    input  logic              trig_i,
    input  logic              tick_pre_i,
    input  logic              tick_near_i,
    input  logic              tick_far_i,
    input  logic              conv_done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              scan_end_i,
    output logic              restart_o,
    output logic [ADDR_W-1:0] restart_val_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] lim_o,
    output logic [2:0]        ch_log_o,
    output logic              wr_o,
    output rate_e             rate_o,
    output logic              samp_tick_o,
    output flag_t             set_o,
    output logic [ADDR_W-1:0] trig_addr_o
);
    localparam logic [ADDR_W-1:0] A_HALF    = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] A_HALF_M1 = A_HALF - 1'b1;
    localparam logic [ADDR_W-1:0] A_TOP     = '1;

    acq_phase_e        phase_q, phase_d;
    acq_mode_e         mode_q;
    logic [2:0]        chl_q;
    logic [CNT_W-1:0]  near_q, far_q, seg_q, seg_d, seg_nx;
    logic [ADDR_W-1:0] trig_addr_q;
    logic              is_cont, is_single, wr_top, wr_half, fin, scan_eoe, trig_cap;

    assign is_cont   = (mode_q == MODE_CONT);
    assign is_single = (mode_q == MODE_SINGLE);
    assign wr_o      = conv_done_i && phase_writes(phase_q) && !arm_i;
    assign wr_top    = wr_o && (addr_i == A_TOP);
    assign wr_half   = wr_o && (addr_i == A_HALF_M1);
    assign seg_nx    = seg_q + 1'b1;
    assign ch_log_o  = chl_q;

    // Address window: circular history in the lower half only before a trigger
    always_comb begin
        base_o = '0;
        lim_o  = (phase_q == PH_PRE && !is_cont) ? A_HALF_M1 : A_TOP;
    end

    always_comb begin
        phase_d       = phase_q;
        seg_d         = seg_q;
        restart_o     = 1'b0;
        restart_val_o = '0;
        fin           = 1'b0;
        scan_eoe      = 1'b0;
        trig_cap      = 1'b0;
        if (arm_i) begin
            phase_d   = (acq_mode_e'(mode_i) == MODE_SINGLE) ? PH_WAIT : PH_PRE;
            seg_d     = '0;
            restart_o = 1'b1;
        end else begin
            unique case (phase_q)
                PH_PRE: if (!is_cont && trig_i) begin
                    restart_o     = 1'b1;
                    restart_val_o = A_HALF;
                    trig_cap      = 1'b1;
                    seg_d         = '0;
                    if (near_q != '0)     phase_d = PH_NEAR;
                    else if (far_q != '0) phase_d = PH_FAR;
                    else begin phase_d = PH_DONE; fin = 1'b1; end
                end
                PH_NEAR: if (wr_top) begin
                    phase_d = PH_DONE; fin = 1'b1;
                end else if (scan_end_i) begin
                    if (seg_nx == near_q) begin
                        seg_d = '0;
                        if (far_q != '0) phase_d = PH_FAR;
                        else begin phase_d = PH_DONE; fin = 1'b1; end
                    end else seg_d = seg_nx;
                end
                PH_FAR: if (wr_top) begin
                    phase_d = PH_DONE; fin = 1'b1;
                end else if (scan_end_i) begin
                    if (seg_nx == far_q) begin phase_d = PH_DONE; fin = 1'b1; end
                    else seg_d = seg_nx;
                end
                PH_WAIT: if (trig_i) begin
                    phase_d = PH_SCAN; seg_d = '0;
                end
                PH_SCAN: if (wr_top) begin
                    phase_d = PH_DONE; scan_eoe = 1'b1;
                end else if (scan_end_i) begin
                    scan_eoe = 1'b1;
                    if (seg_nx >= near_q) begin phase_d = PH_WAIT; seg_d = '0; end
                    else seg_d = seg_nx;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        set_o.half = wr_half;
        set_o.full = wr_top || fin;
        set_o.eoe  = fin || scan_eoe;
    end

    always_comb begin
        unique case (phase_q)
            PH_PRE:  begin rate_o = RATE_PRE;  samp_tick_o = tick_pre_i;  end
            PH_NEAR: begin rate_o = RATE_NEAR; samp_tick_o = tick_near_i; end
            PH_FAR:  begin rate_o = RATE_FAR;  samp_tick_o = tick_far_i;  end
            PH_SCAN: begin rate_o = RATE_NEAR; samp_tick_o = tick_near_i; end
            PH_WAIT: begin rate_o = RATE_NONE; samp_tick_o = trig_i;      end
            default: begin rate_o = RATE_NONE; samp_tick_o = 1'b0;        end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            mode_q      <= MODE_TRIG;
            chl_q       <= '0;
            near_q      <= '0;
            far_q       <= '0;
            seg_q       <= '0;
            trig_addr_q <= '0;
        end else begin
            phase_q <= phase_d;
            seg_q   <= seg_d;
            if (arm_i) begin
                mode_q      <= acq_mode_e'(mode_i);
                chl_q       <= chan_log(chan_code_i);
                near_q      <= near_cnt_i;
                far_q       <= far_cnt_i;
                trig_addr_q <= '0;
            end else if (trig_cap) begin
                trig_addr_q <= addr_i;
            end
        end
    end

    assign trig_addr_o = trig_addr_q;

    // R5
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |-> (!wr_o && !samp_tick_o && rate_o == RATE_NONE));

    // R4
    trig_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PRE && !is_cont && trig_i && !arm_i) |=> (addr_i == A_HALF));

    // R8
    wait_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT) |-> !wr_o);

    // R7
    cont_endless_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PRE && is_cont && !arm_i) |=> (phase_q == PH_PRE));

    // R9
    single_no_pre_chk: assert property (@(posedge clk) disable iff (rst)
        is_single |-> (phase_q != PH_PRE || arm_i));

endmodule

// File: rtl/acq_sequencer.sv
`timescale 1ns/1ps
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        chan_code_i,
    input  logic [CNT_W-1:0]  near_cnt_i,
    input  logic [CNT_W-1:0]  far_cnt_i,
    input  logic              trig_i,
    input  logic              tick_pre_i,
    input  logic              tick_near_i,
    input  logic              tick_far_i,
    input  logic              conv_done_i,
    input  logic [2:0]        clr_i,
    input  logic [2:0]        irq_en_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_en_o,
    output logic [1:0]        rate_o,
    output logic              samp_tick_o,
    output logic [2:0]        flags_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] trig_addr_o
);
    logic              restart, scan_end, wr;
    logic [ADDR_W-1:0] restart_val, base, lim, addr;
    logic [2:0]        ch_log;
    rate_e             rate;
    flag_t             set, flags;

    acq_phase_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .mode_i(mode_i), .chan_code_i(chan_code_i),
        .near_cnt_i(near_cnt_i), .far_cnt_i(far_cnt_i), .trig_i(trig_i),
        .tick_pre_i(tick_pre_i), .tick_near_i(tick_near_i), .tick_far_i(tick_far_i),
        .conv_done_i(conv_done_i), .addr_i(addr), .scan_end_i(scan_end),
        .restart_o(restart), .restart_val_o(restart_val), .base_o(base), .lim_o(lim),
        .ch_log_o(ch_log), .wr_o(wr), .rate_o(rate), .samp_tick_o(samp_tick_o),
        .set_o(set), .trig_addr_o(trig_addr_o)
    );

    acq_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
        .clk(clk), .rst(rst), .restart_i(restart), .restart_val_i(restart_val),
        .wr_i(wr), .base_i(base), .lim_i(lim), .ch_log_i(ch_log),
        .addr_o(addr), .scan_end_o(scan_end)
    );

    acq_flag_bank flag_i (
        .clk(clk), .rst(rst), .clr_all_i(arm_i), .set_i(set), .clr_i(clr_i),
        .en_i(irq_en_i), .flags_o(flags), .irq_o(irq_o)
    );

    assign wr_addr_o = addr;
    assign wr_en_o   = wr;
    assign rate_o    = rate;
    assign flags_o   = flags;

    // R13
    wr_needs_conv_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> conv_done_i);

endmodule

// File: tb/acq_sequencer_tb.sv
`timescale 1ns/1ps
module acq_sequencer_tb_top;
    localparam int AW = 6;
    localparam int CW = 8;
    localparam int HALF = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic arm = 0, trig = 0, tp = 0, tn = 0, tf = 0, conv = 0;
    logic [1:0] mode = 0;
    logic [2:0] chc = 0, clr = 0, en = 0;
    logic [CW-1:0] ncnt = 0, fcnt = 0;
    logic [AW-1:0] wr_addr, trig_addr;
    logic wr_en, stick, irq;
    logic [1:0] rate;
    logic [2:0] flags;

    int n_chk = 0, n_err = 0;
    int exp_q[$];
    bit ended = 0;

    always #5 clk = ~clk;

    acq_sequencer #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm), .mode_i(mode), .chan_code_i(chc),
        .near_cnt_i(ncnt), .far_cnt_i(fcnt), .trig_i(trig), .tick_pre_i(tp),
        .tick_near_i(tn), .tick_far_i(tf), .conv_done_i(conv), .clr_i(clr),
        .irq_en_i(en), .wr_addr_o(wr_addr), .wr_en_o(wr_en), .rate_o(rate),
        .samp_tick_o(stick), .flags_o(flags), .irq_o(irq), .trig_addr_o(trig_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // monitor: every write is compared against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) check("R13 unexpected write addr", int'(wr_addr), -1);
            else check("R1/R3 write address", int'(wr_addr), exp_q.pop_front());
        end
    end

    task automatic cyc;
        @(posedge clk); #1;
    endtask

    task automatic do_arm(input logic [1:0] m, input logic [2:0] c, input int nn, input int ff);
        mode = m; chc = c; ncnt = CW'(nn); fcnt = CW'(ff); arm = 1; cyc; arm = 0;
    endtask

    // driver: one conversion; a >= 0 pushes the expected write address
    task automatic conv1(input int a);
        conv = 1;
        if (a >= 0) exp_q.push_back(a);
        cyc; conv = 0;
    endtask

    task automatic trig1(input logic exp_tick, input string req);
        trig = 1; @(negedge clk); check(req, int'(stick), int'(exp_tick)); cyc; trig = 0;
    endtask

    task automatic look(input string req, input int act, input int exp);
        check(req, act, exp);
    endtask

    initial begin
        #(10 * 100000);
        check("watchdog", 0, 1);
        finish_run;
    end

    initial begin
        repeat (3) cyc;
        rst = 0;
        @(negedge clk);
        look("R2 reset flags", flags, 0);
        look("R10 reset rate", rate, 0);
        look("R13 reset wr_en", wr_en, 0);
        look("R12 reset irq", irq, 0);
        cyc;

        // R7 continuous, 2 channels
        do_arm(2'd1, 3'd1, 0, 0);
        @(negedge clk); look("R10 continuous rate", rate, 1); cyc;
        tp = 1; @(negedge clk); look("R10 pre tick passed", stick, 1); cyc; tp = 0;
        for (int i = 0; i < 32; i++) conv1(i);
        @(negedge clk); look("R7 half after HALF-1", flags, 1); cyc;
        for (int i = 32; i < 64; i++) conv1(i);
        @(negedge clk); look("R7 full after top", flags, 3); cyc;
        trig = 1; cyc; trig = 0;
        for (int i = 0; i < 6; i++) conv1(i);
        @(negedge clk); look("R7 still pre rate after trigger", rate, 1); cyc;

        // R3 R4 R5 triggered, 1 channel, near 3 far 2
        do_arm(2'd0, 3'd0, 3, 2);
        @(negedge clk); look("R2 arm clears flags", flags, 0);
        look("R2 arm address", wr_addr, 0); cyc;
        for (int i = 0; i < 40; i++) conv1(i % HALF);
        @(negedge clk); look("R3 half in history", flags, 1); cyc;
        trig = 1; cyc; trig = 0;
        @(negedge clk); look("R4 trigger address", trig_addr, 8);
        look("R4 restart at HALF", wr_addr, HALF);
        look("R10 near rate", rate, 2); cyc;
        for (int i = 0; i < 3; i++) conv1(HALF + i);
        @(negedge clk); look("R5 far rate", rate, 3); cyc;
        tf = 1; @(negedge clk); look("R10 far tick passed", stick, 1); cyc; tf = 0;
        for (int i = 3; i < 5; i++) conv1(HALF + i);
        @(negedge clk); look("R5 done flags", flags, 7);
        look("R5 done rate", rate, 0); cyc;
        conv1(-1);
        en = 3'b100; @(negedge clk); look("R12 irq eoe enabled", irq, 1); cyc;
        en = 3'b000; @(negedge clk); look("R12 irq masked", irq, 0); cyc;

        // R1 4 channels, near 1 far 1, trigger at once
        do_arm(2'd0, 3'd2, 1, 1);
        trig = 1; cyc; trig = 0;
        @(negedge clk); look("R4 trigger address zero", trig_addr, 0); cyc;
        for (int i = 0; i < 4; i++) conv1(HALF + i);
        @(negedge clk); look("R1 scan of 4 then far", rate, 3); cyc;
        for (int i = 4; i < 8; i++) conv1(HALF + i);
        @(negedge clk); look("R5 done 4ch", flags, 6); cyc;

        // R5 zero counts
        do_arm(2'd3, 3'd0, 0, 0);
        trig = 1; cyc; trig = 0;
        @(negedge clk); look("R5 zero counts flags", flags, 6);
        look("R5 zero counts rate", rate, 0); cyc;
        conv1(-1);

        // R6 post overflow
        do_arm(2'd0, 3'd0, 40, 0);
        trig = 1; cyc; trig = 0;
        for (int i = HALF; i < 64; i++) conv1(i);
        @(negedge clk); look("R6 overflow flags", flags, 6);
        look("R6 overflow rate", rate, 0); cyc;
        conv1(-1);

        // R8 single scan, 2 channels, 2 scans per trigger
        do_arm(2'd2, 3'd1, 2, 0);
        @(negedge clk); look("R8 waiting rate", rate, 0); cyc;
        tp = 1; @(negedge clk); look("R8 no pre tick", stick, 0); cyc; tp = 0;
        conv1(-1);
        trig1(1'b1, "R8 trigger tick");
        @(negedge clk); look("R8 scan rate near", rate, 2); cyc;
        conv1(0); conv1(1);
        @(negedge clk); look("R8 eoe after scan", flags, 4); cyc;
        tn = 1; @(negedge clk); look("R8 near tick passed", stick, 1); cyc; tn = 0;
        conv1(2); conv1(3);
        @(negedge clk); look("R8 back to wait", rate, 0); cyc;
        conv1(-1);
        trig1(1'b1, "R8 second trigger tick");
        for (int i = 4; i < 8; i++) conv1(i);

        // R11 write-one-to-clear
        clr = 3'b100; cyc; clr = 0;
        @(negedge clk); look("R11 eoe cleared", flags, 0); cyc;

        // R9 single scan fills memory, 16 channels
        do_arm(2'd2, 3'd4, 1, 0);
        for (int s = 0; s < 4; s++) begin
            trig1(1'b1, "R9 trigger tick");
            for (int c = 0; c < 16; c++) conv1(s * 16 + c);
        end
        @(negedge clk); look("R9 full flags", flags, 7); cyc;
        trig1(1'b0, "R9 halted trigger");
        en = 3'b010; @(negedge clk); look("R12 irq full", irq, 1); cyc; en = 0;
        clr = 3'b001; cyc; clr = 0;
        @(negedge clk); look("R11 half cleared only", flags, 6); cyc;

        // R2 re-arm
        do_arm(2'd0, 3'd0, 1, 1);
        @(negedge clk); look("R2 re-arm flags", flags, 0);
        look("R2 re-arm address", wr_addr, 0);
        look("R2 re-arm trig addr", trig_addr, 0); cyc;

        repeat (2) cyc;
        look("R13 scoreboard drained", exp_q.size(), 0);
        finish_run;
    end
endmodule